// File: doc/BRIEF.md
# General-Purpose Pin Data Register

This block is the data register of a 16-bit general-purpose pin port. It sits on a CPU bus at one fixed address and takes either halfword or byte accesses. Each pin position has a direction input, supplied by a separate control register. When a pin is set to output, the pin is driven from the stored bit. When a pin is set to input, the pin is left undriven and reads return the live pin level, which has first passed through a two-flop synchronizer.

Three bit positions (15, 14 and 3) are reserved. They are never stored, never driven and always read as zero. The register has two reset inputs. The power-on reset clears the stored value. The manual reset only drops a read response that is still pending, and leaves the contents unchanged. There are no clock-gating inputs, so the register also keeps its value while the clock is stopped.

Top module: `pdr_port`

## Requirements
- R1: The register answers at address 0xFFFFFC84. A halfword access there covers bits 15..8 and 7..0. A byte access at 0xFFFFFC84 covers bits 15..8, and a byte access at 0xFFFFFC85 covers bits 7..0. Any other address or size combination, including a halfword at 0xFFFFFC85, reads zero and does not change the register.
- R2: Bits 15, 14 and 3 (mask 0xC008) always read 0, ignore writes, and keep `pin_oe` and `pin_out` at 0.
- R3: For an implemented bit, `pin_oe` equals its `dir` bit. When `dir` is 1, `pin_out` shows the stored bit, from the clock edge that accepts the write onward.
- R4: A read of a bit whose `dir` is 1 returns the stored bit, whatever the level on `pin_in`.
- R5: A read of a bit whose `dir` is 0 returns `pin_in` through a two-flop synchronizer. A pin change made before clock edge N is seen by a read sampled at edge N+2 or later, and not by a read sampled at edge N+1.
- R6: A write to a bit whose `dir` is 0 still updates the stored bit, but `pin_oe` and `pin_out` stay 0 for that bit. The stored value appears on `pin_out` once `dir` is set to 1.
- R7: While `por_rst` is high, the stored value is cleared to 0x0000. `man_rst` leaves the stored value unchanged.
- R8: A byte write changes only the addressed byte lane. The byte data is taken from its own lane of `wdata`: bits 15..8 for 0xFFFFFC84 and bits 7..0 for 0xFFFFFC85.
- R9: `ready` is high for exactly one cycle, the cycle after each `req`. For a read, `rdata` carries the result in that same cycle. Lanes that were not addressed are zero, and a write returns zero.
- R10: A `man_rst` high at the edge that samples `req` cancels that response, so `ready` stays 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| req | input | 1 | Access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Byte address |
| size_hw | input | 1 | 1 = halfword access, 0 = byte access |
| wdata | input | 16 | Write data, each byte on its own lane |
| dir | input | 16 | Per-pin direction, 1 = output |
| pin_in | input | 16 | Pin levels (asynchronous) |
| pin_out | output | 16 | Pin drive value |
| pin_oe | output | 16 | Pin output enable |
| rdata | output | 16 | Read data, registered |
| ready | output | 1 | Access response, one cycle after `req` |

## Verification
Writes take effect at the edge that samples `req`. The bench therefore checks `pin_out` and the response (`ready`, `rdata`) at the falling edge that follows that edge.

Input-pin reads are due two edges after a pin change. Each table entry waits three cycles after setting `dir` and `pin_in` before it strobes a read. A directed test strobes a read one edge too early and checks that it still returns the old level, then reads again and checks for the new level.

`dir` feeds `pin_oe` and `pin_out` without a register, so those checks follow a single falling edge after `dir` changes.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
    localparam int DW    = 16;
    localparam int AW    = 32;
    localparam int LANES = DW / 8;
    localparam logic [AW-1:0] BASE_ADDR = 32'hFFFF_FC84;
    localparam logic [DW-1:0] IMPL_MASK = 16'h3FF7;

    // lane_en[1] selects bits 15..8, lane_en[0] selects bits 7..0
    typedef struct packed {
        logic             hit;
        logic [LANES-1:0] lane_en;
    } dec_t;

    function automatic dec_t decode(input logic [AW-1:0] a, input logic hw);
        dec_t d;
        logic at_base, at_next;
        at_base = (a == BASE_ADDR);
        at_next = (a == AW'(BASE_ADDR + 1));
        d.lane_en[1] = at_base;
        d.lane_en[0] = (hw && at_base) || (!hw && at_next);
        d.hit        = |d.lane_en;
        return d;
    endfunction

    function automatic logic [DW-1:0] lane_mask(input logic [LANES-1:0] en);
        logic [DW-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{en[i]}};
        return m;
    endfunction
endpackage

// File: rtl/pdr_sync.sv
module pdr_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= async_in[i];
                s2 <= s1;
            end
        end
        assign sync_out[i] = s2;
    end
endmodule

// File: rtl/pdr_store.sv
module pdr_store
    import pdr_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst,
    input  logic             wr,
    input  logic [LANES-1:0] lane_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    q
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (por_rst)
                q[l*8 +: 8] <= '0;
            else if (wr && lane_en[l])
                q[l*8 +: 8] <= wdata[l*8 +: 8] & IMPL_MASK[l*8 +: 8];
        end

        // R8: a lane that is not addressed keeps its value
        assert_lane_hold_R8: assert property (@(posedge clk) disable iff (por_rst)
            !(wr && lane_en[l]) |=> $stable(q[l*8 +: 8]));
    end

    // R7: the contents change only on an accepted write (manual reset included)
    assert_hold_R7: assert property (@(posedge clk) disable iff (por_rst)
        !(wr && (|lane_en)) |=> $stable(q));
endmodule

// File: rtl/pdr_readback.sv
module pdr_readback
    import pdr_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst,
    input  logic             man_rst,
    input  logic             req,
    input  logic             rd,
    input  dec_t             dec,
    input  logic [DW-1:0]    dir,
    input  logic [DW-1:0]    stored,
    input  logic [DW-1:0]    pin_sync,
    output logic [DW-1:0]    rdata,
    output logic             ready
);
    logic [DW-1:0] sel, rd_next;

    always_comb begin
        sel     = ((dir & stored) | (~dir & pin_sync)) & IMPL_MASK;
        rd_next = (rd && dec.hit) ? (sel & lane_mask(dec.lane_en)) : '0;
    end

    always_ff @(posedge clk) begin
        if (por_rst || man_rst) begin
            ready <= 1'b0;
            rdata <= '0;
        end else begin
            ready <= req;
            rdata <= req ? rd_next : '0;
        end
    end

    assert_ready_follows_R9: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        req |=> ready);
    assert_ready_single_R9: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        !req |=> !ready);
    assert_cancel_R10: assert property (@(posedge clk) disable iff (por_rst)
        man_rst |=> !ready);
    assert_rsvd_read_R2: assert property (@(posedge clk) disable iff (por_rst)
        ready |-> ((rdata & ~IMPL_MASK) == '0));
endmodule

// File: rtl/pdr_port.sv
module pdr_port
    import pdr_pkg::*;
(
    input  logic          clk,
    input  logic          por_rst,
    input  logic          man_rst,
    input  logic          req,
    input  logic          we,
    input  logic [31:0]   addr,
    input  logic          size_hw,
    input  logic [15:0]   wdata,
    input  logic [15:0]   dir,
    input  logic [15:0]   pin_in,
    output logic [15:0]   pin_out,
    output logic [15:0]   pin_oe,
    output logic [15:0]   rdata,
    output logic          ready
);
    dec_t          dec;
    logic [DW-1:0] stored, pin_sync;

    assign dec = decode(addr, size_hw);

    pdr_sync #(.WIDTH(DW)) u_sync (
        .clk(clk), .rst(por_rst), .async_in(pin_in), .sync_out(pin_sync)
    );

    pdr_store u_store (
        .clk(clk), .por_rst(por_rst), .wr(req && we), .lane_en(dec.lane_en),
        .wdata(wdata), .q(stored)
    );

    pdr_readback u_rb (
        .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .req(req), .rd(!we),
        .dec(dec), .dir(dir), .stored(stored), .pin_sync(pin_sync),
        .rdata(rdata), .ready(ready)
    );

    assign pin_oe  = dir & IMPL_MASK;
    assign pin_out = stored & dir & IMPL_MASK;

    // R6/R3: a pin that is not enabled is never driven high
    assert_undriven_R6: assert property (@(posedge clk) disable iff (por_rst)
        ((pin_out & ~pin_oe) == '0));
    // R7: power-on reset leaves nothing driven
    assert_por_idle_R7: assert property (@(posedge clk) disable iff (1'b0)
        por_rst |=> (pin_out == '0) && !ready);
endmodule

// File: tb/pdr_port_bench.sv
`timescale 1ns/1ps
module pdr_port_bench;
    logic        clk = 1'b0;
    logic        por_rst, man_rst, req, we, size_hw;
    logic [31:0] addr;
    logic [15:0] wdata, dir, pin_in;
    logic [15:0] pin_out, pin_oe, rdata;
    logic        ready;
    int checks = 0;
    int errors = 0;

    localparam logic [31:0] A0 = 32'hFFFF_FC84;
    localparam logic [31:0] A1 = 32'hFFFF_FC85;
    localparam logic [31:0] AX = 32'hFFFF_FC88;

    always #2.5 clk = ~clk;

    pdr_port u_pdr_port (
        .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .req(req), .we(we),
        .addr(addr), .size_hw(size_hw), .wdata(wdata), .dir(dir), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .rdata(rdata), .ready(ready)
    );

    // {dir, pin, we, addr, hw, wdata, exp_rdata, exp_pin_out}
    localparam int NV = 14;
    localparam logic [113:0] VEC [NV] = '{
        {16'hFFFF, 16'h0000, 1'b1, A0, 1'b1, 16'hFFFF, 16'h0000, 16'h3FF7}, // R2 R3 halfword write
        {16'hFFFF, 16'h0000, 1'b0, A0, 1'b1, 16'h0000, 16'h3FF7, 16'h3FF7}, // R4
        {16'h0000, 16'hA5A5, 1'b0, A0, 1'b1, 16'h0000, 16'h25A5, 16'h0000}, // R5
        {16'h00FF, 16'h0000, 1'b0, A0, 1'b1, 16'h0000, 16'h00F7, 16'h00F7}, // R4 R5 mixed
        {16'h00FF, 16'h0000, 1'b1, A0, 1'b0, 16'h1200, 16'h0000, 16'h00F7}, // R8 high lane
        {16'hFF00, 16'hFFFF, 1'b0, A0, 1'b1, 16'h0000, 16'h12F7, 16'h1200}, // R4 R5
        {16'hFFFF, 16'h0000, 1'b1, A1, 1'b0, 16'h005A, 16'h0000, 16'h1252}, // R8 low lane
        {16'hFFFF, 16'h0000, 1'b0, A1, 1'b0, 16'h0000, 16'h0052, 16'h1252}, // R9 byte read low
        {16'hFFFF, 16'h0000, 1'b0, A0, 1'b0, 16'h0000, 16'h1200, 16'h1252}, // R9 byte read high
        {16'hFFFF, 16'h0000, 1'b1, AX, 1'b1, 16'h0000, 16'h0000, 16'h1252}, // R1 other address
        {16'hFFFF, 16'h0000, 1'b0, AX, 1'b1, 16'h0000, 16'h0000, 16'h1252}, // R1
        {16'hFFFF, 16'h0000, 1'b0, A0, 1'b1, 16'h0000, 16'h1252, 16'h1252}, // R1
        {16'hFFFF, 16'h0000, 1'b1, A1, 1'b1, 16'h0000, 16'h0000, 16'h1252}, // R1 misaligned hw
        {16'hFFFF, 16'h0000, 1'b0, A0, 1'b1, 16'h0000, 16'h1252, 16'h1252}  // R1
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one access for one cycle; returns at the falling edge after the sampling edge
    task automatic access(input logic w, input logic [31:0] a, input logic hw, input logic [15:0] d);
        req = 1'b1; we = w; addr = a; size_hw = hw; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0; wdata = '0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        por_rst = 1'b1; man_rst = 1'b0; req = 1'b0; we = 1'b0; addr = A0;
        size_hw = 1'b1; wdata = '0; dir = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        por_rst = 1'b0;
        check("R7 reset ready", {15'd0, ready}, 16'h0000);
        check("R7 reset pin_out", pin_out, 16'h0000);
        check("R7 reset pin_oe", pin_oe, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            dir = VEC[i][113:98]; pin_in = VEC[i][97:82];
            repeat (3) @(negedge clk);
            access(VEC[i][81], VEC[i][80:49], VEC[i][48], VEC[i][47:32]);
            check($sformatf("R9 vec%0d ready", i), {15'd0, ready}, 16'h0001);
            check($sformatf("R1 R4 R5 vec%0d rdata", i), rdata, VEC[i][31:16]);
            check($sformatf("R3 vec%0d pin_out", i), pin_out, VEC[i][15:0]);
        end
        @(negedge clk);
        check("R9 ready one cycle", {15'd0, ready}, 16'h0000);

        // R2: reserved positions never enabled
        check("R2 pin_oe", pin_oe, 16'h3FF7);

        // R7: manual reset keeps contents
        man_rst = 1'b1;
        @(negedge clk);
        man_rst = 1'b0;
        check("R7 man_rst pin_out", pin_out, 16'h1252);
        access(1'b0, A0, 1'b1, 16'h0);
        check("R7 man_rst readback", rdata, 16'h1252);

        // R10: manual reset cancels a pending response
        man_rst = 1'b1;
        access(1'b0, A0, 1'b1, 16'h0);
        man_rst = 1'b0;
        check("R10 cancelled ready", {15'd0, ready}, 16'h0000);

        // R5: synchronizer latency
        dir = 16'h0000; pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        pin_in = 16'hFFFF;
        @(negedge clk);
        access(1'b0, A0, 1'b1, 16'h0);
        check("R5 too early", rdata, 16'h0000);
        access(1'b0, A0, 1'b1, 16'h0);
        check("R5 after two edges", rdata, 16'h3FF7);

        // R6: write to an input bit does not drive the pin
        pin_in = 16'h0000;
        access(1'b1, A0, 1'b1, 16'h0F0F);
        check("R6 pin_out input", pin_out, 16'h0000);
        check("R6 pin_oe input", pin_oe, 16'h0000);
        dir = 16'hFFFF;
        @(negedge clk);
        check("R6 stored after dir", pin_out, 16'h0F07);

        // R7: power-on reset clears
        por_rst = 1'b1;
        @(negedge clk);
        por_rst = 1'b0;
        check("R7 por pin_out", pin_out, 16'h0000);
        access(1'b0, A0, 1'b1, 16'h0);
        check("R7 por readback", rdata, 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule